// File: doc/BRIEF.md
# Loopback Packet Checker

This block sits at the receive end of a serial loopback test. It takes a 64-bit stream of received words, each with an 8-bit control mask that has one bit per byte lane. It decides whether that stream carries the same packets the transmit side produced. It does not store any copy of the transmitted data. Instead it rebuilds the expected payload locally from a byte counter and compares the two word by word.

Locking needs two start-of-packet words. The first only arms the detector, and the second asserts a sticky data-valid flag. From then on, every start-of-packet word restarts the local reference generator. Every payload word is compared with the generated word in the same position. A single-bit match register drives the pass indicator. It is set by the first good payload comparison, and any payload mismatch clears it until reset.

The receive interface is valid/ready. The checker never applies back-pressure, so `rx_ready` is always high and a word is consumed on every cycle in which `rx_valid` is high. A cycle with `rx_valid` low carries no word and changes no state. `data_valid` and `match` are plain level outputs.

Top module: `loopback_checker`

## Requirements
- R1: While `rst_n` is low and immediately after reset, `data_valid` and `match` are 0 and the start-of-packet count is zero.
- R2: A start-of-packet beat is an accepted beat (rx_valid high) whose byte lane 0 (`rx_data[7:0]`) equals 0xFB and whose control bit 0 (`rx_ctrl[0]`) is 1.
- R3: `data_valid` rises on the clock edge that accepts the second start-of-packet beat after reset, is visible from the next cycle, and stays high until reset; a single start-of-packet beat never raises it.
- R4: A payload beat is an accepted beat with `rx_ctrl` equal to 0 that follows a start-of-packet beat, with no beat carrying a nonzero control mask in between. In the k-th payload beat after a start-of-packet beat (k from 0), byte lane i (`rx_data[8i+7:8i]`) is expected to equal (8k+i) mod 256.
- R5: Words are compared only on payload beats while `data_valid` is high. Beats before lock, beats with any control bit set, and beats outside a packet never change `match`.
- R6: `match` becomes 1 one cycle after the first matching payload comparison. It becomes 0 one cycle after a mismatching comparison, and it stays 0 until reset whatever follows.
- R7: `rx_ready` is always 1. A cycle with `rx_valid` low neither advances the expected sequence nor changes any output.
- R8: Each start-of-packet beat restarts the expected sequence at k = 0, including when a packet is cut short by a new start-of-packet beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Received word present this cycle |
| rx_ready | output | 1 | Checker accepts a word; always 1 |
| rx_data | input | 64 | Received word, byte lane i in bits 8i+7:8i |
| rx_ctrl | input | 8 | Control mask, bit i marks lane i as a control character |
| data_valid | output | 1 | Stream locked after two start-of-packet beats |
| match | output | 1 | Sticky payload match indicator |

## Verification
Both results come from a single register stage. `data_valid` changes one clock edge after the beat that holds the second start-of-packet word. `match` changes one edge after the payload beat whose comparison it reflects. The bench drives each beat on the falling edge and samples both outputs on the following falling edge, so every sample sees the effect of exactly one rising edge. Each check is compared against a bench model, written from the requirements, that has been advanced by that same one beat.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int unsigned LANE_W = 8;
  localparam logic [LANE_W-1:0] SOP_CHAR = 8'hFB;

  typedef struct packed {
    logic sop;
    logic payload;
  } beat_kind_t;
endpackage

// File: rtl/lpc_framer.sv
module lpc_framer
  import lpc_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned SYNC_HITS = 2,
  localparam int unsigned LANES    = DATA_W / LANE_W,
  localparam int unsigned CNT_W    = $clog2(SYNC_HITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [DATA_W-1:0] data,
  input  logic [LANES-1:0]  ctrl,
  output beat_kind_t        kind,
  output logic              locked
);
  logic [CNT_W-1:0] hits_q;
  logic             in_pkt_q;
  logic             locked_q;

  // R2: start-of-packet word detection on lane 0
  always_comb begin
    kind.sop     = beat && ctrl[0] && (data[LANE_W-1:0] == SOP_CHAR);
    kind.payload = beat && in_pkt_q && (ctrl == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hits_q   <= '0;
      in_pkt_q <= 1'b0;
      locked_q <= 1'b0;
    end else if (beat) begin
      if (kind.sop) begin
        in_pkt_q <= 1'b1;
        if (hits_q != CNT_W'(SYNC_HITS)) hits_q <= hits_q + 1'b1;
        if (hits_q == CNT_W'(SYNC_HITS - 1)) locked_q <= 1'b1;
      end else if (ctrl != '0) begin
        in_pkt_q <= 1'b0;
      end
    end
  end

  assign locked = locked_q;

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);
  a_r3_lock_on_sop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(kind.sop) && ($past(hits_q) == CNT_W'(SYNC_HITS - 1)));
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(in_pkt_q) && $stable(hits_q));
endmodule

// File: rtl/lpc_ref_gen.sv
module lpc_ref_gen
  import lpc_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  output logic [DATA_W-1:0] expected
);
  logic [LANE_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       base_q <= '0;
    else if (restart) base_q <= '0;
    else if (advance) base_q <= base_q + LANE_W'(LANES);
  end

  // R4: lane i carries base + i, base steps by the lane count per word
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign expected[i*LANE_W +: LANE_W] = base_q + LANE_W'(i);
  end

  a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (expected[LANE_W-1:0] == '0));
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !restart && !advance |=> $stable(expected));
endmodule

// File: rtl/lpc_comparator.sv
module lpc_comparator #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DATA_W-1:0] received,
  input  logic [DATA_W-1:0] expected,
  output logic              match
);
  logic pass_q;
  logic fail_q;
  logic equal;

  assign equal = (received == expected);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (enable) begin
      if (equal) pass_q <= 1'b1;
      else       fail_q <= 1'b1;
    end
  end

  assign match = pass_q && !fail_q;

  a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |=> !match);
  a_r6_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !equal |=> !match);
  a_r5_only_on_compare: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(match));
endmodule

// File: rtl/loopback_checker.sv
module loopback_checker
  import lpc_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned SYNC_HITS = 2,
  localparam int unsigned LANES    = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [LANES-1:0]  rx_ctrl,
  output logic              data_valid,
  output logic              match
);
  beat_kind_t        kind;
  logic              beat;
  logic              locked;
  logic [DATA_W-1:0] expected;

  assign rx_ready = 1'b1;
  assign beat     = rx_valid && rx_ready;

  lpc_framer #(.DATA_W(DATA_W), .SYNC_HITS(SYNC_HITS)) u_framer (
    .clk(clk), .rst_n(rst_n), .beat(beat), .data(rx_data), .ctrl(rx_ctrl),
    .kind(kind), .locked(locked)
  );

  lpc_ref_gen #(.DATA_W(DATA_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .restart(kind.sop), .advance(kind.payload),
    .expected(expected)
  );

  lpc_comparator #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .enable(kind.payload && locked),
    .received(rx_data), .expected(expected), .match(match)
  );

  assign data_valid = locked;

  a_r5_no_match_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> !match);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> !data_valid && !match);
endmodule

// File: tb/tb_loopback_checker.sv
module tb_loopback_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [63:0] rx_data = '0;
  logic [7:0]  rx_ctrl = 8'hFF;
  logic        data_valid;
  logic        match;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model state
  int m_hits, m_k;
  bit m_dv, m_inpkt, m_pass, m_fail;

  always #2.5 clk = ~clk;

  loopback_checker dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_ctrl(rx_ctrl), .data_valid(data_valid), .match(match)
  );

  function automatic logic [63:0] exp_word(int k);
    logic [63:0] w;
    for (int i = 0; i < 8; i++) w[i*8 +: 8] = 8'((8*k + i) % 256);
    return w;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_hits = 0; m_k = 0; m_dv = 0; m_inpkt = 0; m_pass = 0; m_fail = 0;
  endtask

  // one cycle: drive at falling edge, model, sample at next falling edge
  task automatic step(bit v, logic [63:0] d, logic [7:0] c, string req);
    bit sop;
    rx_valid = v; rx_data = d; rx_ctrl = c;
    if (v) begin
      sop = c[0] && d[7:0] == 8'hFB;
      if (m_inpkt && c == 8'h00) begin
        if (m_dv) begin
          if (d == exp_word(m_k)) m_pass = 1; else m_fail = 1;
        end
        m_k++;
      end
      if (sop) begin
        m_inpkt = 1; m_k = 0;
        if (m_hits < 2) m_hits++;
        if (m_hits == 2) m_dv = 1;
      end else if (c != 8'h00) m_inpkt = 0;
    end
    @(negedge clk);
    check({req, " data_valid"}, data_valid, m_dv);
    check({req, " match"}, match, m_pass && !m_fail);
    check("R7 rx_ready", rx_ready, 1'b1);
  endtask

  task automatic do_reset();
    rst_n = 0; rx_valid = 0; rx_ctrl = 8'hFF;
    model_reset();
    repeat (2) @(negedge clk);
    check("R1 data_valid", data_valid, 1'b0);
    check("R1 match", match, 1'b0);
    rst_n = 1;
  endtask

  task automatic send_sop(string req);
    step(1, 64'hD555_5555_5555_55FB, 8'h01, req);
  endtask
  task automatic send_idle();
    step(1, 64'h0707_0707_0707_0707, 8'hFF, "R5");
  endtask
  task automatic send_term();
    step(1, 64'h0707_0707_0707_07FD, 8'hFF, "R5");
  endtask
  task automatic send_payload(int n, int bad_at, string req);
    for (int k = 0; k < n; k++) begin
      logic [63:0] w = exp_word(k);
      if (k == bad_at) w[($urandom % 8) * 8 +: 8] ^= 8'h01 << ($urandom % 8);
      if ($urandom % 5 == 0) step(0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, "R7");
      step(1, w, 8'h00, req);
    end
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset();
    // R3: one SOP is not enough; payload before lock is not compared (R5)
    send_idle();
    send_sop("R3");
    send_payload(3, 1, "R5");
    send_term();
    // R2: wrong control bit or wrong char is not a SOP
    step(1, 64'h0000_0000_0000_00FB, 8'h00, "R2");
    step(1, 64'h0000_0000_0000_00FC, 8'h01, "R2");
    // R7: bubble with SOP pattern but valid low
    step(0, 64'h0000_0000_0000_00FB, 8'h01, "R7");
    send_idle();
    send_sop("R3");
    check("R3 locked after second SOP", data_valid, 1'b1);
    send_payload(4, -1, "R4");
    check("R6 match after good payload", match, 1'b1);
    // R8: packet cut short by new SOP restarts sequence
    send_sop("R8");
    send_payload(2, -1, "R8");
    send_term();
    // R5: garbage in control words does not disturb match
    step(1, 64'h1234_5678_9ABC_DEF0, 8'h80, "R5");
    send_idle();
    // R6: mismatch clears and sticks
    send_sop("R6");
    send_payload(5, 2, "R6");
    send_term();
    check("R6 sticky low", match, 1'b0);
    send_sop("R6");
    send_payload(6, -1, "R6");
    send_term();

    // constrained random sessions
    for (int s = 0; s < 20; s++) begin
      do_reset();
      for (int p = 0; p < 30; p++) begin
        int gap = $urandom % 4;
        int len = 1 + $urandom % 40;
        int bad = ($urandom % 25 == 0) ? int'($urandom % len) : -1;
        for (int g = 0; g < gap; g++) send_idle();
        send_sop("R4");
        send_payload(len, bad, "R4");
        if ($urandom % 6 != 0) send_term();
      end
    end

    // long packet to wrap the byte counter (R4)
    do_reset();
    send_sop("R3"); send_term(); send_sop("R3");
    send_payload(70, -1, "R4");
    send_term();
    check("R4 wrap match", match, 1'b1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule